// File: doc/BRIEF.md
# Codec Register Status Read Responder

This block is the register-access side of an audio codec on a frame-based serial link. It works with the parallel form of each outgoing frame. On each frame it receives the tag word (slot 0), the command word (slot 1) and the write-data word (slot 2), together with a pulse marking the frame boundary. It decodes whether the frame is a register read or write aimed at this codec. Writes are applied to a small register file. For a read, the block builds the tag, address-echo and read-data words that the codec places in its very next incoming frame.

The codec is given a 2-bit ID on `codec_id`. With ID 0 it acts as the primary codec and trusts the address and data tag bits. With a non-zero ID it acts as a secondary codec: it answers only frames whose tag carries its own ID, and it takes the command read/write bit to decide whether write data is present. The register map is a parameter table. Each entry gives an even address, a writable-bit mask, a constant pattern for read-only bits, and a reset value. Any address not in the table is answered with zero data, and so is any odd address.

Top module: `codec_status_responder`

## Requirements
- R1: A read accepted in the frame marked by a `frame_strobe` pulse is answered on the outputs from the clock edge that samples that pulse. The answer is held until the next pulse, so it occupies exactly the next frame.
- R2: A read answer carries tag bits 15, 14 and 13 all set. Tag bits 12 to 0, including the ID field in bits 1:0, are always 0, whatever `codec_id` is.
- R3: A read of an address not in the table echoes the 7-bit address in `in_addr` bits 18:12 and returns zero in `in_rdata`.
- R4: An odd address is handled like an address not in the table. A read returns zero data and echoes the odd address. A write changes nothing, including the even register just below it.
- R5: Read data sits in `in_rdata` bits 19:4, and bits 3:0 are 0. A register bit that is neither writable nor a fixed read-only one always reads 0. Fixed read-only bits read as their parameter value.
- R6: With `codec_id` = 0, a frame is accepted when tag bit 15 is set, tag bits 1:0 are 00 and tag bit 14 (address valid) is set. Command bit 19 = 1 means read. A write also needs tag bit 13 (data valid).
- R7: With `codec_id` non-zero, a frame is accepted when tag bit 15 is set and tag bits 1:0 equal `codec_id`. Command bit 19 alone selects read (1) or write (0), and tag bits 14:13 are not used.
- R8: An accepted write to a table address changes only the bits set in that entry's writable mask, taking them from `out_wdata` bits 19:4. Writes to other addresses have no effect.
- R9: A frame with tag bit 15 clear, or one that does not match as in R6 and R7, causes no register access and no read answer.
- R10: After reset all outputs are 0. After the first frame pulse, a frame with no read answer shows `in_tag` = 8000h, with `in_addr` and `in_rdata` at zero.
- R11: The outputs change only on a clock edge that samples `frame_strobe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One-cycle pulse: the slot words of an outgoing frame are valid |
| codec_id | input | 2 | This codec's ID; 0 means primary |
| out_tag | input | 16 | Outgoing slot 0 tag word |
| out_cmd | input | 20 | Outgoing slot 1: bit 19 read, bits 18:12 address |
| out_wdata | input | 20 | Outgoing slot 2: write data in bits 19:4 |
| in_tag | output | 16 | Incoming slot 0 tag word for the next frame |
| in_addr | output | 20 | Incoming slot 1: echoed address in bits 18:12 |
| in_rdata | output | 20 | Incoming slot 2: read data in bits 19:4 |

## Verification
The bench reads an odd address and then checks the even register just below it after an odd write. A design that aliases odd addresses would return that register's contents or corrupt them. The bench writes all-ones to registers with mixed writable, fixed and reserved bits, which shows any design that leaks reserved bits or lets fixed bits be written. It sends primary frames without the address or data tag bits, and secondary frames with a wrong ID. A decoder that is too permissive would answer these or write on them. It also checks that each answer lasts exactly one frame and does not drift between pulses.

// File: rtl/codec_status_responder.sv
module codec_status_responder #(
  parameter int NREG = 4,
  parameter logic [NREG*7-1:0]  REG_ADDRS = {7'h7C, 7'h18, 7'h04, 7'h02},
  parameter logic [NREG*16-1:0] REG_WMASK = {16'h0000, 16'h00FF, 16'h9F1F, 16'hBF3F},
  parameter logic [NREG*16-1:0] REG_FIXED = {16'h4144, 16'h8000, 16'h0000, 16'h0000},
  parameter logic [NREG*16-1:0] REG_INIT  = {16'h0000, 16'h0008, 16'h0000, 16'h8000}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_strobe,
  input  logic [1:0]  codec_id,
  input  logic [15:0] out_tag,
  input  logic [19:0] out_cmd,
  input  logic [19:0] out_wdata,
  output logic [15:0] in_tag,
  output logic [19:0] in_addr,
  output logic [19:0] in_rdata
);

  localparam int AW = 7;
  localparam int DW = 16;
  localparam logic [15:0] TAG_IDLE = 16'h8000;
  localparam logic [15:0] TAG_RESP = 16'hE000;

  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic          is_read;
  logic          prim_hit, sec_hit, rd_req, wr_req;
  logic [NREG-1:0] hit;
  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] rd_vals [NREG];
  logic [DW-1:0] rd_word;

  wire unused_bits = ^{out_tag[12:2], out_cmd[11:0], out_wdata[3:0]};

  assign req_addr = out_cmd[18:12];
  assign req_data = out_wdata[19:4];
  assign is_read  = out_cmd[19];

  assign prim_hit = out_tag[15] && (codec_id == 2'b00) && (out_tag[1:0] == 2'b00) && out_tag[14];
  assign sec_hit  = out_tag[15] && (codec_id != 2'b00) && (out_tag[1:0] == codec_id);
  assign rd_req   = frame_strobe && (prim_hit || sec_hit) && is_read;
  assign wr_req   = frame_strobe && !is_read && (sec_hit || (prim_hit && out_tag[13]));

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [AW-1:0] ADDR  = REG_ADDRS[i*AW +: AW];
    localparam logic [DW-1:0] WMASK = REG_WMASK[i*DW +: DW];
    localparam logic [DW-1:0] FIXED = REG_FIXED[i*DW +: DW] & ~WMASK;
    localparam logic [DW-1:0] INIT  = REG_INIT[i*DW +: DW] & WMASK;

    assign hit[i] = !req_addr[0] && (req_addr == ADDR);

    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= INIT;
      else if (wr_req && hit[i])
        regs[i] <= (regs[i] & ~WMASK) | (req_data & WMASK);
    end

    assign rd_vals[i] = hit[i] ? ((regs[i] & WMASK) | FIXED) : '0;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NREG; i++) rd_word = rd_word | rd_vals[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_tag   <= '0;
      in_addr  <= '0;
      in_rdata <= '0;
    end else if (frame_strobe) begin
      in_tag   <= rd_req ? TAG_RESP : TAG_IDLE;
      in_addr  <= rd_req ? {1'b0, req_addr, 12'h000} : '0;
      in_rdata <= rd_req ? {rd_word, 4'h0} : '0;
    end
  end

  // R1
  read_resp_next_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && out_cmd[19] && out_tag[15] &&
     (((codec_id == 2'b00) && (out_tag[1:0] == 2'b00) && out_tag[14]) ||
      ((codec_id != 2'b00) && (out_tag[1:0] == codec_id))))
    |=> (in_tag[15:13] == 3'b111) && (in_addr[18:12] == $past(out_cmd[18:12])));

  // R2
  status_id_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_tag[12:0] == 13'h0);

  // R4
  odd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && out_cmd[19] && out_cmd[12]) |=> (in_rdata == 20'h0));

  // R8
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

  // R9
  invalid_frame_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_strobe && !out_tag[15]) |=> (in_tag[14:13] == 2'b00) && (in_addr == 20'h0) && (in_rdata == 20'h0));

  // R10
  idle_slots_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_tag[14] |-> (in_addr == 20'h0) && (in_rdata == 20'h0));

  // R11
  hold_between_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_strobe |=> $stable(in_tag) && $stable(in_addr) && $stable(in_rdata));

endmodule

// File: tb/test_codec_status_responder.sv
module test_codec_status_responder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_strobe = 1'b0;
  logic [1:0]  codec_id = 2'b00;
  logic [15:0] out_tag = '0;
  logic [19:0] out_cmd = '0;
  logic [19:0] out_wdata = '0;
  logic [15:0] in_tag;
  logic [19:0] in_addr;
  logic [19:0] in_rdata;

  int vectors = 0;
  int miscompares = 0;

  always #2.5 clk = ~clk;

  codec_status_responder i_codec_status_responder (
    .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe), .codec_id(codec_id),
    .out_tag(out_tag), .out_cmd(out_cmd), .out_wdata(out_wdata),
    .in_tag(in_tag), .in_addr(in_addr), .in_rdata(in_rdata));

  function automatic logic [19:0] rd_cmd(input logic [6:0] a);
    return {1'b1, a, 12'h000};
  endfunction
  function automatic logic [19:0] wr_cmd(input logic [6:0] a);
    return {1'b0, a, 12'h000};
  endfunction

  task automatic check(input string req, input logic [15:0] et, input logic [19:0] ea, input logic [19:0] ed);
    vectors++;
    if (in_tag !== et || in_addr !== ea || in_rdata !== ed) begin
      miscompares++;
      $display("FAIL %s: got tag=%h addr=%h data=%h expected tag=%h addr=%h data=%h",
               req, in_tag, in_addr, in_rdata, et, ea, ed);
    end
  endtask

  task automatic frame(input logic [15:0] t, input logic [19:0] c, input logic [19:0] d);
    @(negedge clk);
    out_tag = t; out_cmd = c; out_wdata = d; frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0; out_tag = '0; out_cmd = '0; out_wdata = '0;
  endtask

  task automatic prim_read(input logic [6:0] a);
    frame(16'hE000, rd_cmd(a), '0);
  endtask
  task automatic prim_write(input logic [6:0] a, input logic [15:0] v);
    frame(16'hE000, wr_cmd(a), {v, 4'h0});
  endtask

  task automatic t_reset;
    check("R10 reset", 16'h0000, 20'h0, 20'h0);
  endtask

  task automatic t_invalid_first;
    frame(16'h6000, rd_cmd(7'h02), '0);
    check("R9 R10 invalid frame idle", 16'h8000, 20'h0, 20'h0);
  endtask

  task automatic t_basic_read;
    prim_read(7'h02);
    check("R1 R2 R6 primary read", 16'hE000, 20'h02000, 20'h80000);
    repeat (4) @(negedge clk);
    check("R11 hold between pulses", 16'hE000, 20'h02000, 20'h80000);
    frame(16'h8000, '0, '0);
    check("R1 answer lasts one frame", 16'h8000, 20'h0, 20'h0);
  endtask

  task automatic t_masked_write;
    prim_write(7'h02, 16'hFFFF);
    check("R8 write frame gives idle", 16'h8000, 20'h0, 20'h0);
    prim_read(7'h02);
    check("R5 R8 masked write 02", 16'hE000, 20'h02000, 20'hBF3F0);
    prim_read(7'h7C);
    check("R5 fixed bits 7C", 16'hE000, 20'h7C000, 20'h41440);
    prim_write(7'h7C, 16'hFFFF);
    prim_read(7'h7C);
    check("R8 read-only unchanged", 16'hE000, 20'h7C000, 20'h41440);
    prim_read(7'h18);
    check("R5 mixed reset value 18", 16'hE000, 20'h18000, 20'h80080);
    prim_write(7'h18, 16'h7FAB);
    prim_read(7'h18);
    check("R5 R8 mixed write 18", 16'hE000, 20'h18000, 20'h80AB0);
  endtask

  task automatic t_unimpl_odd;
    prim_read(7'h26);
    check("R3 unimplemented read", 16'hE000, 20'h26000, 20'h0);
    prim_read(7'h03);
    check("R4 odd read no alias", 16'hE000, 20'h03000, 20'h0);
    prim_write(7'h03, 16'h1234);
    prim_write(7'h26, 16'hFFFF);
    prim_read(7'h02);
    check("R4 R8 odd write ignored", 16'hE000, 20'h02000, 20'hBF3F0);
  endtask

  task automatic t_primary_tags;
    frame(16'hC000, wr_cmd(7'h04), {16'h1F1F, 4'h0});
    prim_read(7'h04);
    check("R6 write without data tag ignored", 16'hE000, 20'h04000, 20'h0);
    frame(16'hA000, rd_cmd(7'h02), '0);
    check("R6 read without address tag", 16'h8000, 20'h0, 20'h0);
    frame(16'h6000, rd_cmd(7'h02), '0);
    check("R9 frame not valid", 16'h8000, 20'h0, 20'h0);
  endtask

  task automatic t_secondary;
    codec_id = 2'b10;
    prim_read(7'h02);
    check("R9 primary frame at secondary", 16'h8000, 20'h0, 20'h0);
    frame(16'h8002, rd_cmd(7'h02), '0);
    check("R7 R2 secondary read", 16'hE000, 20'h02000, 20'hBF3F0);
    frame(16'h8001, rd_cmd(7'h02), '0);
    check("R9 id mismatch", 16'h8000, 20'h0, 20'h0);
    frame(16'h8001, wr_cmd(7'h04), {16'hFFFF, 4'h0});
    frame(16'h8002, rd_cmd(7'h04), '0);
    check("R9 mismatched write ignored", 16'hE000, 20'h04000, 20'h0);
    frame(16'h8002, wr_cmd(7'h04), {16'hFFFF, 4'h0});
    frame(16'h8002, rd_cmd(7'h04), '0);
    check("R7 R8 secondary write", 16'hE000, 20'h04000, 20'h9F1F0);
    codec_id = 2'b00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_invalid_first();
    t_basic_read();
    t_masked_write();
    t_unimpl_odd();
    t_primary_tags();
    t_secondary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(200000 * 5);
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule